// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of physical buffer segments, each an address and a byte length, into the 64-bit entries of a bus-master descriptor table. A job begins with a one-cycle start pulse that latches the number of bytes to move and the largest number of entries the table may hold. Segments then arrive on a valid/ready stream. The block cuts each segment into pieces that never straddle a 64 KiB physical page and sends each piece out as one descriptor on a second valid/ready stream. The piece that completes the requested byte total carries the end-of-table flag.

A job that cannot be expressed as a direct table ends with a fault code. This happens for an odd or zero length, an odd address, or more pieces than the table can hold. The caller then takes a bounce-buffer path. After a fault, the block swallows any further segments and keeps the code visible until the next start pulse. A clean job ends with a one-cycle done pulse that reports the number of entries produced.

Top module: `sgd_table_builder`

## Requirements
- R1: After reset, desc_valid, done and seg_ready are low and fault_code is 0.
- R2: Each descriptor holds the piece base address in bits 31:0 and the piece byte count in bits 47:32, where a count of 65536 is written as 0. Bits 55:48 are zero. Bits 63:56 are a flags byte in which only bit 63 may be set.
- R3: No descriptor covers bytes in two different 64 KiB pages. A segment that runs past a page end is cut at the next page start, and the remainder continues as a new descriptor whose base is that page start.
- R4: Bit 63 is set on exactly one descriptor per clean job: the one whose bytes bring the running sum up to the requested total.
- R5: When the requested total ends inside a segment, only the bytes up to the total are described. No further segment is accepted (seg_ready stays low).
- R6: A segment with an even, nonzero length and an odd address sets fault_code to 1 (misaligned), and no descriptor follows it.
- R7: A segment length that is zero or odd sets fault_code to 2 (bad length), even when the address is also odd. An odd requested total also sets fault_code to 2 at start.
- R8: If a job needs more descriptors than the latched capacity, exactly capacity descriptors are emitted and fault_code becomes 3 (table full). A job that needs exactly capacity descriptors completes cleanly.
- R9: A clean job raises done for one cycle, the cycle after its last descriptor is accepted, with done_count equal to the number of descriptors. A requested total of 0 gives done with count 0.
- R10: While fault_code is nonzero, seg_ready is high, segments are discarded, desc_valid stays low and fault_code holds. A start pulse clears fault_code to 0.
- R11: A descriptor offered with desc_ready low stays valid with the same word until it is accepted, unless a start pulse or a fault voids the job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job and latches total_len and capacity |
| total_len | input | TOT_W | Bytes to describe in this job |
| capacity | input | CNT_W | Most descriptors the table may hold (clamped to MAX_ENTRIES) |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment taken when high together with seg_valid |
| seg_addr | input | 32 | Segment physical address |
| seg_len | input | LEN_W | Segment length in bytes |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_word | output | 64 | Descriptor word |
| done | output | 1 | One-cycle pulse when a clean job finishes |
| done_count | output | CNT_W | Descriptor count of the finished job |
| fault_code | output | 2 | 0 none, 1 misaligned, 2 bad length, 3 table full |

## Verification
The bench targets segments that straddle one or two page ends, including a page-aligned 128 KiB segment that must become two 64 KiB pieces written with count 0. An off-by-one in the cut would either cross a page or leave a stray two-byte piece. It ends a total halfway through the second of three segments. A design that ignored the total would describe the whole segment or accept the third one. It places odd lengths on odd addresses to pin down fault priority, and it runs jobs with capacity one below and exactly at the needed count, where a fencepost error would fault too early or emit one entry too many. Descriptors are pulled under toggling backpressure, so an output stage that dropped or repeated a held word would show up as a changed entry list.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int DESC_W = 64;
    localparam logic [7:0] FLAG_END = 8'h80;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_ALIGN = 2'd1,
        FLT_LEN   = 2'd2,
        FLT_FULL  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } state_e;

    // Descriptor layout, most significant field first
    typedef struct packed {
        logic [7:0]  flags;
        logic [7:0]  rsvd;
        logic [15:0] count;
        logic [31:0] base;
    } entry_t;

    function automatic entry_t pack_entry(input logic [31:0] base,
                                          input logic [15:0] count,
                                          input logic        is_last);
        entry_t e;
        e.base  = base;
        e.count = count;
        e.rsvd  = 8'h00;
        e.flags = is_last ? FLAG_END : 8'h00;
        return e;
    endfunction

endpackage

// File: rtl/sgd_seg_check.sv
module sgd_seg_check
    import sgd_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             addr_lsb,
    input  logic [LEN_W-1:0] len,
    output fault_e           verdict
);
    // Length problems outrank address problems
    always_comb begin
        if (len == '0 || len[0])
            verdict = FLT_LEN;
        else if (addr_lsb)
            verdict = FLT_ALIGN;
        else
            verdict = FLT_NONE;
    end
endmodule

// File: rtl/sgd_cutter.sv
module sgd_cutter #(
    parameter int LEN_W     = 24,
    parameter int TOT_W     = 32,
    parameter int PAGE_BITS = 16
) (
    input  logic [PAGE_BITS-1:0] page_off,
    input  logic [LEN_W-1:0]     left,
    input  logic [TOT_W-1:0]     rem,
    output logic [TOT_W-1:0]     piece,
    output logic                 piece_last
);
    localparam int SPAN_W = PAGE_BITS + 1;

    logic [SPAN_W-1:0] to_edge;
    logic [TOT_W-1:0]  left_w;
    logic [TOT_W-1:0]  edge_w;
    logic [TOT_W-1:0]  first_min;

    // Bytes from the current address up to the next page start
    assign to_edge = {1'b1, {PAGE_BITS{1'b0}}} - {1'b0, page_off};

    generate
        if (TOT_W > LEN_W) begin : g_widen_left
            assign left_w = {{(TOT_W-LEN_W){1'b0}}, left};
        end else begin : g_same_left
            assign left_w = left[TOT_W-1:0];
        end
    endgenerate

    assign edge_w     = {{(TOT_W-SPAN_W){1'b0}}, to_edge};
    assign first_min  = (left_w < rem) ? left_w : rem;
    assign piece      = (first_min < edge_w) ? first_min : edge_w;
    assign piece_last = (piece == rem);
endmodule

// File: rtl/sgd_out_slot.sv
module sgd_out_slot #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (load && !flush)
            dout <= din;
    end
endmodule

// File: rtl/sgd_table_builder.sv
module sgd_table_builder
    import sgd_pkg::*;
#(
    parameter int LEN_W       = 24,
    parameter int TOT_W       = 32,
    parameter int MAX_ENTRIES = 1024,
    parameter int PAGE_BITS   = 16,
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TOT_W-1:0]  total_len,
    input  logic [CNT_W-1:0]  capacity,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [31:0]       seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [63:0]       desc_word,
    output logic              done,
    output logic [CNT_W-1:0]  done_count,
    output logic [1:0]        fault_code
);
    localparam logic [CNT_W-1:0] CAP_MAX = CNT_W'(MAX_ENTRIES);

    state_e             state_q;
    fault_e             fault_q;
    logic [TOT_W-1:0]   rem_q;
    logic [CNT_W-1:0]   cap_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   done_cnt_q;
    logic [31:0]        cur_addr_q;
    logic [LEN_W-1:0]   cur_left_q;
    logic               done_q;

    fault_e             seg_verdict;
    logic [TOT_W-1:0]   piece;
    logic               piece_last;
    entry_t             new_entry;
    logic               slot_free;
    logic               seg_take;
    logic               have_seg;
    logic               cut_go;
    logic               full_hit;
    logic               finish;
    logic               fault_set;
    logic               slot_flush;
    logic [CNT_W-1:0]   cap_in;

    sgd_seg_check #(.LEN_W(LEN_W)) u_check (
        .addr_lsb (seg_addr[0]),
        .len      (seg_len),
        .verdict  (seg_verdict)
    );

    sgd_cutter #(
        .LEN_W     (LEN_W),
        .TOT_W     (TOT_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_cut (
        .page_off   (cur_addr_q[PAGE_BITS-1:0]),
        .left       (cur_left_q),
        .rem        (rem_q),
        .piece      (piece),
        .piece_last (piece_last)
    );

    assign new_entry = pack_entry(cur_addr_q, piece[15:0], piece_last);

    // Handshake and step conditions
    assign slot_free = !desc_valid || desc_ready;
    assign have_seg  = (state_q == ST_RUN) && (cur_left_q != '0);
    assign seg_ready = ((state_q == ST_RUN) && (cur_left_q == '0) && (rem_q != '0))
                     || (state_q == ST_FAULT);
    assign seg_take  = seg_valid && seg_ready && (state_q == ST_RUN) && !start;
    assign cut_go    = have_seg && slot_free && (cnt_q != cap_q) && !start;
    assign full_hit  = have_seg && slot_free && (cnt_q == cap_q) && !start;
    assign finish    = (state_q == ST_RUN) && (rem_q == '0) && !desc_valid && !start;
    assign fault_set = (seg_take && (seg_verdict != FLT_NONE)) || full_hit;
    assign slot_flush = start || fault_set;
    assign cap_in    = (capacity > CAP_MAX) ? CAP_MAX : capacity;

    sgd_out_slot #(.W(DESC_W)) u_slot (
        .clk   (clk),
        .rst   (rst),
        .flush (slot_flush),
        .load  (cut_go),
        .din   (new_entry),
        .ready (desc_ready),
        .valid (desc_valid),
        .dout  (desc_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            fault_q    <= FLT_NONE;
            rem_q      <= '0;
            cap_q      <= '0;
            cnt_q      <= '0;
            done_cnt_q <= '0;
            cur_addr_q <= '0;
            cur_left_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q      <= total_len;
                cap_q      <= cap_in;
                cnt_q      <= '0;
                cur_left_q <= '0;
                if (total_len[0]) begin
                    state_q <= ST_FAULT;
                    fault_q <= FLT_LEN;
                end else begin
                    state_q <= ST_RUN;
                    fault_q <= FLT_NONE;
                end
            end else begin
                unique case (state_q)
                    ST_RUN: begin
                        if (seg_take) begin
                            if (seg_verdict != FLT_NONE) begin
                                fault_q <= seg_verdict;
                                state_q <= ST_FAULT;
                            end else begin
                                cur_addr_q <= seg_addr;
                                cur_left_q <= seg_len;
                            end
                        end else if (full_hit) begin
                            fault_q    <= FLT_FULL;
                            state_q    <= ST_FAULT;
                            cur_left_q <= '0;
                        end else if (cut_go) begin
                            cur_addr_q <= cur_addr_q + piece[31:0];
                            cur_left_q <= piece_last ? '0
                                        : cur_left_q - piece[LEN_W-1:0];
                            rem_q      <= rem_q - piece;
                            cnt_q      <= cnt_q + 1'b1;
                        end else if (finish) begin
                            done_q     <= 1'b1;
                            done_cnt_q <= cnt_q;
                            state_q    <= ST_IDLE;
                        end
                    end
                    ST_FAULT: begin
                        state_q <= ST_FAULT;
                    end
                    default: begin
                        state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign done       = done_q;
    assign done_count = done_cnt_q;
    assign fault_code = fault_q;

endmodule

// File: rtl/sgd_table_builder_chk.sv
module sgd_table_builder_chk #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             seg_valid,
    input logic             seg_ready,
    input logic             seg_addr_lsb,
    input logic [LEN_W-1:0] seg_len,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [63:0]      desc_word,
    input logic             done,
    input logic [1:0]       fault_code
);
    logic [32:0] span;
    logic [32:0] last_byte;

    assign span      = (desc_word[47:32] == 16'h0) ? 33'h1_0000 : {17'h0, desc_word[47:32]};
    assign last_byte = {1'b0, desc_word[31:0]} + span - 33'd1;

    // R3
    no_page_cross_chk: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (last_byte[31:16] == desc_word[31:16]));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (desc_word[62:48] == 15'h0));

    // R11
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc_ready && !start) |=>
            ((desc_valid && $stable(desc_word)) || (fault_code != 2'd0)));

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 2'd0) |-> (!desc_valid && seg_ready && !done));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((fault_code != 2'd0) && !start) |=> (fault_code == $past(fault_code)));

    // R6
    misalign_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && seg_ready && (fault_code == 2'd0) && !start && seg_addr_lsb
         && (seg_len != '0) && !seg_len[0]) |=> (fault_code == 2'd1));

    // R7
    bad_len_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && seg_ready && (fault_code == 2'd0) && !start
         && ((seg_len == '0) || seg_len[0])) |=> (fault_code == 2'd2));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind sgd_table_builder sgd_table_builder_chk #(.LEN_W(LEN_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_addr_lsb (seg_addr[0]),
    .seg_len      (seg_len),
    .desc_valid   (desc_valid),
    .desc_ready   (desc_ready),
    .desc_word    (desc_word),
    .done         (done),
    .fault_code   (fault_code)
);

// File: tb/sgd_table_builder_tb_top.sv
module sgd_table_builder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 24;
    localparam int TOT_W = 32;
    localparam int MAXE  = 1024;
    localparam int CNT_W = $clog2(MAXE + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [TOT_W-1:0] total_len = '0;
    logic [CNT_W-1:0] capacity = '0;
    logic             seg_valid = 1'b0;
    logic             seg_ready;
    logic [31:0]      seg_addr = '0;
    logic [LEN_W-1:0] seg_len = '0;
    logic             desc_valid;
    logic             desc_ready = 1'b0;
    logic [63:0]      desc_word;
    logic             done;
    logic [CNT_W-1:0] done_count;
    logic [1:0]       fault_code;

    sgd_table_builder #(.LEN_W(LEN_W), .TOT_W(TOT_W), .MAX_ENTRIES(MAXE)) dut_i (
        .clk(clk), .rst(rst), .start(start), .total_len(total_len),
        .capacity(capacity), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .desc_valid(desc_valid),
        .desc_ready(desc_ready), .desc_word(desc_word), .done(done),
        .done_count(done_count), .fault_code(fault_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int rmode = 0;

    logic [31:0]      sa [0:7];
    logic [LEN_W-1:0] sl [0:7];
    int               ns = 0;
    int               accepted = 0;

    logic [63:0] got [0:63];
    int          ngot = 0;
    bit          done_seen = 0;
    int          done_val = 0;

    logic [63:0] ew [0:63];
    int          ne = 0;
    int          ef = 0;

    always @(posedge clk) cyc++;

    // Consumer readiness pattern, changed away from the active edge
    always @(negedge clk) begin
        case (rmode)
            0:       desc_ready <= 1'b1;
            1:       desc_ready <= cyc[0];
            default: desc_ready <= (cyc % 3 == 0);
        endcase
    end

    // Collector samples the handshake at the edge
    always @(posedge clk) begin
        if (!rst) begin
            if (desc_valid && desc_ready && ngot < 64) begin
                got[ngot] = desc_word;
                ngot++;
            end
            if (done) begin
                done_seen = 1;
                done_val  = int'(done_count);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected table computed from the cutting and fault rules
    task automatic build_ref(input longint total, input int cap);
        longint rem = total;
        ne = 0;
        ef = 0;
        if (total % 2 != 0) begin
            ef = 2;
            return;
        end
        for (int i = 0; i < ns && rem > 0 && ef == 0; i++) begin
            longint a    = longint'(sa[i]);
            longint left = longint'(sl[i]);
            if (left == 0 || left % 2 != 0) begin ef = 2; break; end
            if (a % 2 != 0) begin ef = 1; break; end
            while (left > 0 && rem > 0) begin
                longint gap = 65536 - (a % 65536);
                longint p = left;
                if (rem < p) p = rem;
                if (gap < p) p = gap;
                if (ne == cap) begin ef = 3; break; end
                ew[ne] = {8'h00, 8'h00, 16'(p), 32'(a)};
                ne++;
                a += p;
                left -= p;
                rem -= p;
            end
        end
        if (ef == 0 && ne > 0) ew[ne-1][63] = 1'b1;
    endtask

    task automatic run_job(input longint total, input int cap, input int mode);
        @(negedge clk);
        ngot = 0;
        done_seen = 0;
        accepted = 0;
        rmode = mode;
        start = 1'b1;
        total_len = TOT_W'(total);
        capacity = CNT_W'(cap);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < ns; i++) begin
            int  w = 0;
            bit  took = 0;
            seg_valid = 1'b1;
            seg_addr  = sa[i];
            seg_len   = sl[i];
            while (!took && !done_seen && w < 3000) begin
                took = seg_ready;
                @(negedge clk);
                w++;
            end
            if (took) accepted++;
            else break;
        end
        seg_valid = 1'b0;
        for (int w = 0; w < 3000 && !done_seen && fault_code == 2'd0; w++)
            @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_list(input string req);
        chk(ngot == ne, req, "entry count", ngot, ne);
        for (int i = 0; i < ne && i < ngot; i++)
            chk(got[i] == ew[i], req, "entry word", longint'(got[i]), longint'(ew[i]));
    endtask

    task automatic t_reset();
        // R1
        chk(desc_valid == 1'b0, "R1", "desc_valid", desc_valid, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(seg_ready == 1'b0, "R1", "seg_ready", seg_ready, 0);
        chk(fault_code == 2'd0, "R1", "fault_code", fault_code, 0);
    endtask

    task automatic t_plain();
        ns = 2;
        sa[0] = 32'h0000_1000; sl[0] = 24'h200;
        sa[1] = 32'h0000_3000; sl[1] = 24'h400;
        build_ref(64'h600, 16);
        run_job(64'h600, 16, 0);
        expect_list("R2");
        chk(ngot == 2 && got[1][63] == 1'b1 && got[0][63] == 1'b0, "R4", "end flag placement",
            ngot, 2);
        chk(done_seen && done_val == 2, "R9", "done count", done_val, 2);
        chk(fault_code == 2'd0, "R9", "no fault", fault_code, 0);
    endtask

    task automatic t_cross();
        ns = 2;
        sa[0] = 32'h0001_FF00; sl[0] = 24'h300;
        sa[1] = 32'h0003_0000; sl[1] = 24'h2_0000;
        build_ref(64'h2_0300, 16);
        run_job(64'h2_0300, 16, 1);
        // R3 and R11: page cuts under toggling backpressure
        expect_list("R3");
        chk(ngot == 4 && got[1][31:0] == 32'h0002_0000, "R3", "cut at page start",
            longint'(got[1][31:0]), 64'h2_0000);
        chk(ngot == 4 && got[2][47:32] == 16'h0, "R2", "64 KiB written as 0",
            longint'(got[2][47:32]), 0);
        chk(done_seen && done_val == 4, "R11", "all entries delivered", done_val, 4);
    endtask

    task automatic t_partial();
        ns = 3;
        sa[0] = 32'h0000_4000; sl[0] = 24'h1000;
        sa[1] = 32'h0000_8000; sl[1] = 24'h1000;
        sa[2] = 32'h0000_C000; sl[2] = 24'h1000;
        build_ref(64'h1800, 16);
        run_job(64'h1800, 16, 2);
        expect_list("R5");
        chk(accepted == 2, "R5", "segments taken", accepted, 2);
        chk(seg_ready == 1'b0, "R5", "seg_ready after end", seg_ready, 0);
        chk(ngot == 2 && got[1][63] == 1'b1, "R4", "flag on cut piece", ngot, 2);
    endtask

    task automatic t_align();
        ns = 2;
        sa[0] = 32'h0000_5001; sl[0] = 24'h100;
        sa[1] = 32'h0000_6000; sl[1] = 24'h100;
        run_job(64'h200, 16, 0);
        chk(fault_code == 2'd1, "R6", "misaligned code", fault_code, 1);
        chk(ngot == 0, "R6", "no descriptors", ngot, 0);
        // R10: discard while faulted
        chk(seg_ready == 1'b1, "R10", "seg_ready while faulted", seg_ready, 1);
        seg_valid = 1'b1; seg_addr = 32'h0000_7000; seg_len = 24'h40;
        repeat (4) @(negedge clk);
        seg_valid = 1'b0;
        chk(desc_valid == 1'b0 && ngot == 0, "R10", "no output after fault", ngot, 0);
        chk(fault_code == 2'd1, "R10", "code holds", fault_code, 1);
        // R10: start clears
        ns = 1;
        sa[0] = 32'h0000_2000; sl[0] = 24'h80;
        build_ref(64'h80, 16);
        run_job(64'h80, 16, 0);
        chk(fault_code == 2'd0, "R10", "start clears code", fault_code, 0);
        expect_list("R10");
    endtask

    task automatic t_badlen();
        ns = 1;
        sa[0] = 32'h0000_6000; sl[0] = 24'h0;
        run_job(64'h100, 16, 0);
        chk(fault_code == 2'd2, "R7", "zero length", fault_code, 2);
        sa[0] = 32'h0000_6001; sl[0] = 24'h3;
        run_job(64'h100, 16, 0);
        chk(fault_code == 2'd2, "R7", "odd length beats odd address", fault_code, 2);
        sa[0] = 32'h0000_6000; sl[0] = 24'h100;
        run_job(64'h81, 16, 0);
        chk(fault_code == 2'd2 && ngot == 0, "R7", "odd total", fault_code, 2);
    endtask

    task automatic t_cap();
        ns = 3;
        sa[0] = 32'h0000_1000; sl[0] = 24'h100;
        sa[1] = 32'h0000_2000; sl[1] = 24'h100;
        sa[2] = 32'h0000_3000; sl[2] = 24'h100;
        build_ref(64'h300, 2);
        run_job(64'h300, 2, 0);
        chk(fault_code == 2'd3 && ef == 3, "R8", "table full code", fault_code, 3);
        chk(ngot == 2, "R8", "entries before full", ngot, 2);
        chk(!done_seen, "R8", "no done on full", done_seen, 0);
        build_ref(64'h300, 3);
        run_job(64'h300, 3, 0);
        expect_list("R8");
        chk(done_seen && done_val == 3 && fault_code == 2'd0, "R8", "exact fit", done_val, 3);
    endtask

    task automatic t_zero();
        ns = 0;
        run_job(64'h0, 16, 0);
        chk(done_seen && done_val == 0, "R9", "zero total done", done_val, 0);
        chk(ngot == 0, "R9", "zero total no entries", ngot, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_cross();
        t_partial();
        t_align();
        t_badlen();
        t_cap();
        t_zero();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule